// File: doc/BRIEF.md
# Streaming Systematic Reed-Solomon Encoder

This block turns a stream of m-bit data symbols into systematic Reed-Solomon codewords over GF(2^m). Each data symbol leaves the block unchanged, in arrival order. Once the last data symbol of a codeword has gone through, the block emits the parity symbols. Those are the remainder of the message polynomial, shifted up by the parity count, after division by the generator polynomial. The symbol width, the field polynomial (given as its integer value with x set to 2), the parity count, the exponent of the first generator root and the exponent step between roots are all parameters. The generator coefficients are computed from these parameters during elaboration. The primitive element is 2.

A codeword opens when a symbol arrives with the start flag set. The codeword length n is sampled alongside that symbol. The data count is k = n − NCHK, so a shortened code only needs its k real symbols: no zero padding is supplied. The block deasserts its ready output while it sends parity, so a source can start the next codeword on the cycle after the last parity symbol leaves the datapath. An optional input register adds one cycle of latency.

Top module: `rs_encoder`

## Requirements
- R1: Each parity symbol equals the matching coefficient of the remainder of d(x)·x^NCHK divided by g(x) = ∏ over i = 0..NCHK−1 of (x + α^(ROOTSPACE·(GSTART+i))), with α = 2. Data symbol 0 is the highest-degree coefficient of d(x). Multiplication is reduced by FIELD_POLY.
- R2: Output order is the k data symbols unchanged, then the NCHK parity symbols, highest degree first. out_chk is 1 exactly on parity symbols.
- R3: out_sof is 1 on the first data symbol of a codeword. out_eof is 1 on its last parity symbol, and only there.
- R4: in_len (n) is sampled with the start symbol, and k = n − NCHK data symbols follow, the start symbol included. n may be any value from NCHK+1 up to 2^m − 1. This covers shortened codes such as (204,188) with 8-bit symbols.
- R5: The first output symbol appears after the third rising edge when REG_IN = 1, and after the second rising edge when REG_IN = 0. The edge that samples the first data symbol is counted as the first.
- R6: After the last data symbol is accepted, in_ready is 0 for exactly NCHK cycles and then returns to 1. The next codeword may then start back to back.
- R7: A start symbol that arrives inside an open codeword begins a new codeword with a cleared remainder. The interrupted codeword emits no parity.
- R8: A valid symbol without the start flag, while no codeword is open, is dropped and produces no output.
- R9: After reset, out_valid is 0 and in_ready is 1.
- R10: Every complete output codeword evaluates to zero at each generator root α^(ROOTSPACE·(GSTART+i)).
- R11: Cycles with in_valid low inside a codeword pause it without changing the parity result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol qualifier |
| in_sof | input | 1 | Start of codeword, marks the first data symbol |
| in_data | input | SYM_W | Data symbol |
| in_len | input | SYM_W | Codeword length n, sampled with in_sof |
| in_ready | output | 1 | Input accepted when this and in_valid are high |
| out_valid | output | 1 | Output symbol qualifier |
| out_sof | output | 1 | First symbol of a codeword |
| out_eof | output | 1 | Last parity symbol of a codeword |
| out_chk | output | 1 | Output symbol is a parity symbol |
| out_data | output | SYM_W | Output symbol |

## Verification
Two corners are hard to reach from the ports. The first is a codeword start that lands on the exact cycle after the previous parity burst ends. The bench reaches it by watching in_ready fall, counting the low cycles, and driving the next start flag on the first cycle ready returns high. The second is a start flag in the middle of an open codeword. The bench sends ten symbols of a codeword and then a new start. It expects the partial symbols to pass through with no parity, and the following codeword to match a long-division model. That can only happen if the remainder was cleared. Orphan symbols sent while idle, and a one-symbol codeword, cover the two extremes of the data count.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic {
        CORE_PASS  = 1'b0,
        CORE_PARITY = 1'b1
    } core_phase_e;

    // Constant-time GF(2^w) product on integers, reduced by poly.
    function automatic int gf_mul_c(int a, int b, int poly, int w);
        int p;
        p = 0;
        for (int i = w - 1; i >= 0; i--) begin
            p = p << 1;
            if (((p >> w) & 1) == 1) p = p ^ poly;
            if (((b >> i) & 1) == 1) p = p ^ a;
        end
        return p;
    endfunction

    // alpha^e with alpha = 2.
    function automatic int alpha_pow(int e, int poly, int w);
        int r;
        int period;
        int ee;
        period = (1 << w) - 1;
        ee = e % period;
        r = 1;
        for (int i = 0; i < ee; i++) r = gf_mul_c(r, 2, poly, w);
        return r;
    endfunction

endpackage

// File: rtl/rs_gf_mult.sv
module rs_gf_mult #(
    parameter int W    = 8,
    parameter int POLY = 285
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] RED = POLY[W-1:0];

    always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (acc[W-1]) acc = (acc << 1) ^ RED;
            else          acc = acc << 1;
            if (b[i]) acc = acc ^ a;
        end
        y = acc;
    end
endmodule

// File: rtl/rs_front.sv
module rs_front #(
    parameter int SYM_W  = 8,
    parameter int NCHK   = 16,
    parameter bit REG_IN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [SYM_W-1:0] in_data,
    input  logic [SYM_W-1:0] in_len,
    output logic             in_ready,
    output logic             f_valid,
    output logic             f_sof,
    output logic             f_last,
    output logic [SYM_W-1:0] f_data
);
    localparam int GAP_W = $clog2(NCHK + 1);

    logic             open_q;
    logic [SYM_W-1:0] left_q;
    logic [GAP_W-1:0] gap_q;
    logic             accept;
    logic [SYM_W-1:0] k_new;
    logic             t_valid;
    logic             t_last;

    assign in_ready = (gap_q == '0);
    assign accept   = in_valid && in_ready;
    assign k_new    = in_len - SYM_W'(NCHK);
    assign t_valid  = accept && (in_sof || open_q);
    assign t_last   = in_sof ? (k_new == SYM_W'(1)) : (left_q == SYM_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            left_q <= '0;
            gap_q  <= '0;
        end else if (t_valid) begin
            if (t_last) begin
                open_q <= 1'b0;
                gap_q  <= GAP_W'(NCHK);
            end else begin
                open_q <= 1'b1;
                left_q <= in_sof ? (k_new - SYM_W'(1)) : (left_q - SYM_W'(1));
            end
        end else if (gap_q != '0) begin
            gap_q <= gap_q - GAP_W'(1);
        end
    end

    generate
        if (REG_IN) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_valid <= 1'b0;
                    f_sof   <= 1'b0;
                    f_last  <= 1'b0;
                    f_data  <= '0;
                end else begin
                    f_valid <= t_valid;
                    f_sof   <= in_sof;
                    f_last  <= t_last;
                    f_data  <= in_data;
                end
            end
        end else begin : g_wire
            assign f_valid = t_valid;
            assign f_sof   = in_sof;
            assign f_last  = t_last;
            assign f_data  = in_data;
        end
    endgenerate

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (t_valid && t_last) |=> !in_ready);

    // R6
    ready_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(t_valid && t_last));
endmodule

// File: rtl/rs_lfsr.sv
module rs_lfsr
    import rs_pkg::*;
#(
    parameter int SYM_W     = 8,
    parameter int POLY      = 285,
    parameter int NCHK      = 16,
    parameter int GSTART    = 0,
    parameter int ROOTSPACE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             f_valid,
    input  logic             f_sof,
    input  logic             f_last,
    input  logic [SYM_W-1:0] f_data,
    output logic             m_valid,
    output logic             m_sof,
    output logic             m_last,
    output logic             m_chk,
    output logic [SYM_W-1:0] m_data
);
    localparam int CNT_W = $clog2(NCHK + 1);

    typedef logic [NCHK-1:0][SYM_W-1:0] stages_t;

    function automatic stages_t make_gen();
        int g [0:NCHK];
        int root;
        stages_t res;
        for (int j = 0; j <= NCHK; j++) g[j] = 0;
        g[0] = 1;
        for (int i = 0; i < NCHK; i++) begin
            root = alpha_pow(ROOTSPACE * (GSTART + i), POLY, SYM_W);
            for (int j = i + 1; j >= 1; j--)
                g[j] = g[j-1] ^ gf_mul_c(g[j], root, POLY, SYM_W);
            g[0] = gf_mul_c(g[0], root, POLY, SYM_W);
        end
        for (int j = 0; j < NCHK; j++) res[j] = SYM_W'(g[j]);
        return res;
    endfunction

    localparam stages_t GEN = make_gen();

    core_phase_e      phase_q;
    stages_t          rem_q;
    stages_t          base;
    stages_t          prod;
    stages_t          nxt;
    logic [SYM_W-1:0] fb;
    logic [CNT_W-1:0] left_q;

    assign base = f_sof ? '0 : rem_q;
    assign fb   = f_data ^ base[NCHK-1];

    generate
        for (genvar j = 0; j < NCHK; j++) begin : g_stage
            rs_gf_mult #(.W(SYM_W), .POLY(POLY)) u_mul (
                .a(fb),
                .b(GEN[j]),
                .y(prod[j])
            );
            if (j == 0) begin : g_first
                assign nxt[j] = prod[j];
            end else begin : g_rest
                assign nxt[j] = base[j-1] ^ prod[j];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= CORE_PASS;
            rem_q   <= '0;
            left_q  <= '0;
            m_valid <= 1'b0;
            m_sof   <= 1'b0;
            m_last  <= 1'b0;
            m_chk   <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= 1'b0;
            m_sof   <= 1'b0;
            m_last  <= 1'b0;
            m_chk   <= 1'b0;
            if (phase_q == CORE_PARITY) begin
                m_valid <= 1'b1;
                m_chk   <= 1'b1;
                m_data  <= rem_q[NCHK-1];
                rem_q   <= {rem_q[NCHK-2:0], {SYM_W{1'b0}}};
                left_q  <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) begin
                    m_last  <= 1'b1;
                    phase_q <= CORE_PASS;
                end
            end else if (f_valid) begin
                m_valid <= 1'b1;
                m_sof   <= f_sof;
                m_data  <= f_data;
                rem_q   <= nxt;
                if (f_last) begin
                    phase_q <= CORE_PARITY;
                    left_q  <= CNT_W'(NCHK);
                end
            end
        end
    end

    // R6
    no_input_in_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == CORE_PARITY) |-> !f_valid);

    // R2
    parity_run_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == CORE_PARITY && left_q != CNT_W'(1)) |=> (phase_q == CORE_PARITY));
endmodule

// File: rtl/rs_encoder.sv
module rs_encoder #(
    parameter int SYM_W     = 8,
    parameter int FIELD_POLY = 285,
    parameter int NCHK      = 16,
    parameter int GSTART    = 0,
    parameter int ROOTSPACE = 1,
    parameter bit REG_IN    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [SYM_W-1:0] in_data,
    input  logic [SYM_W-1:0] in_len,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_chk,
    output logic [SYM_W-1:0] out_data
);
    typedef struct packed {
        logic             valid;
        logic             sof;
        logic             eof;
        logic             chk;
        logic [SYM_W-1:0] data;
    } out_sym_t;

    logic             f_valid, f_sof, f_last;
    logic [SYM_W-1:0] f_data;
    logic             m_valid, m_sof, m_last, m_chk;
    logic [SYM_W-1:0] m_data;
    out_sym_t         out_q;

    rs_front #(.SYM_W(SYM_W), .NCHK(NCHK), .REG_IN(REG_IN)) u_front (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_len(in_len),
        .in_ready(in_ready),
        .f_valid(f_valid), .f_sof(f_sof), .f_last(f_last), .f_data(f_data)
    );

    rs_lfsr #(.SYM_W(SYM_W), .POLY(FIELD_POLY), .NCHK(NCHK),
              .GSTART(GSTART), .ROOTSPACE(ROOTSPACE)) u_core (
        .clk(clk), .rst(rst),
        .f_valid(f_valid), .f_sof(f_sof), .f_last(f_last), .f_data(f_data),
        .m_valid(m_valid), .m_sof(m_sof), .m_last(m_last), .m_chk(m_chk),
        .m_data(m_data)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= '{valid: m_valid, sof: m_sof, eof: m_last,
                            chk: m_chk, data: m_data};
    end

    assign out_valid = out_q.valid;
    assign out_sof   = out_q.sof;
    assign out_eof   = out_q.eof;
    assign out_chk   = out_q.chk;
    assign out_data  = out_q.data;

    // R3
    eof_on_parity_chk: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (out_valid && out_chk));

    // R2
    sof_on_data_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_valid && !out_chk));

    // R2
    parity_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
        (out_chk && !out_eof) |=> (out_valid && out_chk));
endmodule

// File: tb/rs_encoder_test.sv
module rs_encoder_test;
    localparam int W     = 8;
    localparam int POLY  = 285;
    localparam int NC    = 16;
    localparam int GS    = 0;
    localparam int RSP   = 1;
    localparam bit REGI  = 1'b1;
    localparam int LAT   = REGI ? 3 : 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0, in_sof = 1'b0;
    logic [W-1:0] in_data = '0, in_len = '0;
    logic         in_ready, out_valid, out_sof, out_eof, out_chk;
    logic [W-1:0] out_data;

    rs_encoder #(.SYM_W(W), .FIELD_POLY(POLY), .NCHK(NC), .GSTART(GS),
                 .ROOTSPACE(RSP), .REG_IN(REGI)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .in_len(in_len), .in_ready(in_ready),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_chk(out_chk), .out_data(out_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    data;
        bit    sof;
        bit    eof;
        bit    chk;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0;
    int   last_acc = 0, first_acc = 0, first_out = 0;
    bit   lat_arm = 0;
    int   out_seen = 0;
    int   roots[NC];
    int   gen[NC+1];
    int   cw[$];
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int gfm(int a, int b);
        int r, x;
        r = 0;
        x = a;
        for (int i = 0; i < W; i++) begin
            if (((b >> i) & 1) == 1) r = r ^ x;
            x = x << 1;
            if (((x >> W) & 1) == 1) x = x ^ POLY;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Scoreboard monitor, away from the active edge.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            out_seen++;
            if (lat_arm) begin
                first_out = cyc;
                lat_arm = 0;
            end
            if (q.size() == 0) begin
                check(0, "R8 unexpected output", int'(out_data), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(out_data) == e.data && out_sof == e.sof &&
                      out_eof == e.eof && out_chk == e.chk,
                      e.tag, {out_sof, out_eof, out_chk, out_data},
                      {e.sof, e.eof, e.chk, e.data[W-1:0]});
            end
            if (out_sof) cw.delete();
            cw.push_back(int'(out_data));
            if (out_eof) begin
                for (int r = 0; r < NC; r++) begin
                    int acc;
                    acc = 0;
                    foreach (cw[i]) acc = gfm(acc, roots[r]) ^ cw[i];
                    check(acc == 0, "R10 codeword at root", acc, 0);
                end
            end
        end
    end

    task automatic put_sym(int d, bit sof, int n);
        in_valid = 1'b1;
        in_sof   = sof;
        in_data  = W'(d);
        in_len   = W'(n);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 last_acc = cyc;
        @(negedge clk);
    endtask

    task automatic idle(int cycles);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // Long-division reference and drive of one complete codeword.
    task automatic send_block(int n, int bubble_every, bit zeros, string tag);
        int k;
        int msg[256];
        int d[256];
        int gap;
        k = n - NC;
        for (int i = 0; i < 256; i++) msg[i] = 0;
        for (int i = 0; i < k; i++) begin
            d[i] = zeros ? 0 : int'($urandom_range(0, (1 << W) - 1));
            msg[i] = d[i];
        end
        for (int i = 0; i < k; i++) begin
            int c;
            c = msg[i];
            for (int j = 1; j <= NC; j++) msg[i+j] = msg[i+j] ^ gfm(c, gen[NC-j]);
        end
        for (int i = 0; i < k; i++)
            q.push_back('{d[i], i == 0, 0, 0, {tag, " R2 data"}});
        for (int j = 0; j < NC; j++)
            q.push_back('{msg[k+j], 0, j == NC - 1, 1, {tag, " R1 R3 parity"}});
        for (int i = 0; i < k; i++) begin
            put_sym(d[i], i == 0, n);
            if (i == 0) first_acc = last_acc;
            if (bubble_every > 0 && (i % bubble_every) == bubble_every - 1) idle(2);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        gap = 0;
        while (!in_ready) begin
            gap++;
            @(negedge clk);
        end
        check(gap == NC, "R6 ready low cycles", gap, NC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        for (int i = 0; i <= NC; i++) gen[i] = 0;
        gen[0] = 1;
        for (int i = 0; i < NC; i++) begin
            int e, rt;
            e = (RSP * (GS + i)) % ((1 << W) - 1);
            rt = 1;
            for (int t = 0; t < e; t++) rt = gfm(rt, 2);
            roots[i] = rt;
            for (int j = i + 1; j >= 1; j--) gen[j] = gen[j-1] ^ gfm(gen[j], rt);
            gen[0] = gfm(gen[0], rt);
        end

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);

        // Full-length code, continuous input, latency measured.
        lat_arm = 1;
        send_block(255, 0, 0, "full255");
        check(first_out - first_acc == LAT - 1, "R5 latency edges",
              first_out - first_acc + 1, LAT);

        // Shortened (204,188) with bubbles in the stream.
        send_block(204, 3, 0, "short204 R4 R11");

        // Back-to-back codewords.
        send_block(204, 0, 0, "b2b_a R6");
        send_block(100, 0, 0, "b2b_b R4");

        // Smallest data count, k = 1.
        send_block(NC + 1, 0, 0, "min_k R4");

        // Orphan symbols while idle must be dropped.
        idle(4);
        out_seen = 0;
        for (int i = 0; i < 5; i++) put_sym(i + 7, 0, 204);
        idle(LAT + 4);
        check(out_seen == 0, "R8 orphan symbols output count", out_seen, 0);

        // Restart in the middle of an open codeword.
        for (int i = 0; i < 10; i++) begin
            int v;
            v = 100 + i;
            q.push_back('{v, i == 0, 0, 0, "R7 partial data"});
            put_sym(v, i == 0, 204);
        end
        send_block(204, 0, 0, "restart R7");

        // All-zero message gives all-zero parity.
        send_block(255, 0, 1, "zeros R1");

        idle(LAT + NC + 8);
        check(q.size() == 0, "R2 all expected symbols produced", q.size(), 0);
        finish_up();
    end
endmodule